// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a 64-bit integer ALU that treats each operand as a set of independent lanes: eight 8-bit, four 16-bit or two 32-bit lanes, chosen per operation by a width code. Carries never cross a lane boundary. Sums and differences can wrap, clamp as signed values or clamp as unsigned values. The block also provides per-lane shifts, whole-word bitwise logic, compares that write all-ones or all-zeros lane masks, a 16-bit lane multiply, a pairwise multiply-accumulate into 32-bit lanes, and a narrowing pack with signed saturation.

An operation is presented with `in_valid`, an opcode, a width code and two operands. The result appears one clock later on a registered output with `out_valid`. Back-to-back issue is allowed at one operation per cycle. When no operation is issued, the output register keeps its last value.

Top module: `simd_sat_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.
- R2: An operation accepted with `in_valid` high produces its `result` and a high `out_valid` on the next rising edge. In any cycle after a cycle with `in_valid` low, `out_valid` is 0 and `result` keeps its previous value.
- R3: Opcodes 0 (add) and 3 (subtract, A minus B) wrap modulo the lane size. Lane size comes from `wsel`: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. No carry or borrow passes between lanes.
- R4: Opcodes 1 (add) and 4 (subtract) saturate as signed values. A lane that overflows is clamped to the most positive or most negative value of its lane.
- R5: Opcodes 2 (add) and 5 (subtract) saturate as unsigned values. A sum that overflows gives all ones in the lane, and a difference that would go below zero gives zero.
- R6: Opcodes 6 (shift left), 7 (logical shift right) and 8 (arithmetic shift right) shift every lane of A by the unsigned 64-bit count in B. A count at or above the lane width gives zero for opcodes 6 and 7, and gives copies of the lane's sign bit for opcode 8.
- R7: Opcodes 9 (A and B), 10 ((not A) and B), 11 (A or B) and 12 (A xor B) act on the whole 64-bit word and ignore `wsel`.
- R8: Opcode 13 (equal) and opcode 14 (signed A greater than B) set each result lane to all ones when the condition holds and to all zeros when it does not.
- R9: Opcode 15 always uses four 16-bit lanes, whatever `wsel` holds. Each lane receives the low 16 bits of the product of the A and B lanes.
- R10: Opcode 16 forms the signed products of the 16-bit lanes. Result 32-bit lane j receives the sum of the products of 16-bit lanes 2j and 2j+1, wrapped to 32 bits.
- R11: Opcode 17 narrows signed lanes with saturation. If `wsel` is 2 or 3, lanes go from 32 to 16 bits; otherwise they go from 16 to 8 bits. The narrowed lanes of A fill the low half of the result in lane order, and those of B fill the high half. Any other opcode gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 5 | Opcode |
| wsel | input | 2 | Lane width code |
| a | input | 64 | Operand A |
| b | input | 64 | Operand B, or the shift count |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |

## Verification
Two events can fall on the same edge: the output register capturing a new result, and the block accepting the next operation whose result follows one cycle later. The bench issues long runs of back-to-back operations of different kinds and widths, such as a saturating add followed at once by a compare or a pack. A scoreboard queue pairs every result with the operation that produced it, so any slip in timing or any mix-up between operations shows up as a mismatch. Within a single operation, lane saturation and lane partitioning also meet. Operands are chosen so that one lane overflows while its neighbour stays in range, which shows that a clamp or a carry stays inside its own lane.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int DATA_W = 64;
    localparam int OP_W   = 5;
    localparam int WSEL_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDS  = 5'd1,
        OP_ADDUS = 5'd2,
        OP_SUB   = 5'd3,
        OP_SUBS  = 5'd4,
        OP_SUBUS = 5'd5,
        OP_SLL   = 5'd6,
        OP_SRL   = 5'd7,
        OP_SRA   = 5'd8,
        OP_AND   = 5'd9,
        OP_ANDN  = 5'd10,
        OP_OR    = 5'd11,
        OP_XOR   = 5'd12,
        OP_CEQ   = 5'd13,
        OP_CGT   = 5'd14,
        OP_MUL   = 5'd15,
        OP_MADD  = 5'd16,
        OP_PACK  = 5'd17
    } simd_op_e;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } out_stage_t;

endpackage

// File: rtl/simd_lane.sv
module simd_lane #(
    parameter int LW = 8
) (
    input  logic [LW-1:0]          a,
    input  logic [LW-1:0]          b,
    input  logic                   sub,
    input  logic                   sat_s,
    input  logic                   sat_u,
    input  logic [$clog2(LW)-1:0]  shamt,
    input  logic                   sh_big,
    output logic [LW-1:0]          sum,
    output logic [LW-1:0]          shl,
    output logic [LW-1:0]          shr,
    output logic [LW-1:0]          sra,
    output logic [LW-1:0]          ceq,
    output logic [LW-1:0]          cgt
);

    localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};

    logic [LW-1:0] bx_d;
    logic [LW:0]   raw_d;
    logic          s_ovf_d;

    always_comb begin
        bx_d    = sub ? ~b : b;
        raw_d   = {1'b0, a} + {1'b0, bx_d} + {{LW{1'b0}}, sub};
        s_ovf_d = (a[LW-1] == bx_d[LW-1]) && (raw_d[LW-1] != a[LW-1]);
        sum     = raw_d[LW-1:0];
        if (sat_s && s_ovf_d) begin
            sum = a[LW-1] ? SMIN : SMAX;
        end else if (sat_u) begin
            if (!sub && raw_d[LW]) sum = {LW{1'b1}};
            if (sub && !raw_d[LW]) sum = {LW{1'b0}};
        end
    end

    always_comb begin
        shl = sh_big ? {LW{1'b0}} : (a << shamt);
        shr = sh_big ? {LW{1'b0}} : (a >> shamt);
        sra = sh_big ? {LW{a[LW-1]}} : LW'($signed(a) >>> shamt);
        ceq = {LW{a == b}};
        cgt = {LW{$signed(a) > $signed(b)}};
    end

endmodule

// File: rtl/simd_lanes.sv
module simd_lanes
    import simd_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [WSEL_W-1:0] wsel,
    input  logic              sub,
    input  logic              sat_s,
    input  logic              sat_u,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] shl,
    output logic [DATA_W-1:0] shr,
    output logic [DATA_W-1:0] sra,
    output logic [DATA_W-1:0] ceq,
    output logic [DATA_W-1:0] cgt
);

    localparam int NW = 3;

    logic [NW-1:0][DATA_W-1:0] sum_w, shl_w, shr_w, sra_w, ceq_w, cgt_w;

    for (genvar g = 0; g < NW; g++) begin : g_width
        localparam int LW = 8 << g;
        localparam int NL = DATA_W / LW;
        localparam int SH = $clog2(LW);

        logic          big;
        logic [SH-1:0] amt;

        assign big = (b >= DATA_W'(LW));
        assign amt = b[SH-1:0];

        for (genvar k = 0; k < NL; k++) begin : g_lane
            logic [LW-1:0] o_sum, o_shl, o_shr, o_sra, o_ceq, o_cgt;

            simd_lane #(.LW(LW)) u_lane (
                .a      (a[k*LW +: LW]),
                .b      (b[k*LW +: LW]),
                .sub    (sub),
                .sat_s  (sat_s),
                .sat_u  (sat_u),
                .shamt  (amt),
                .sh_big (big),
                .sum    (o_sum),
                .shl    (o_shl),
                .shr    (o_shr),
                .sra    (o_sra),
                .ceq    (o_ceq),
                .cgt    (o_cgt)
            );

            assign sum_w[g][k*LW +: LW] = o_sum;
            assign shl_w[g][k*LW +: LW] = o_shl;
            assign shr_w[g][k*LW +: LW] = o_shr;
            assign sra_w[g][k*LW +: LW] = o_sra;
            assign ceq_w[g][k*LW +: LW] = o_ceq;
            assign cgt_w[g][k*LW +: LW] = o_cgt;
        end
    end

    logic [1:0] idx_d;

    always_comb begin
        idx_d = wsel[1] ? 2'd2 : {1'b0, wsel[0]};
        sum   = sum_w[idx_d];
        shl   = shl_w[idx_d];
        shr   = shr_w[idx_d];
        sra   = sra_w[idx_d];
        ceq   = ceq_w[idx_d];
        cgt   = cgt_w[idx_d];
    end

endmodule

// File: rtl/simd_mul.sv
module simd_mul
    import simd_pkg::*;
#(
    parameter int ML = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] mul_lo,
    output logic [DATA_W-1:0] madd
);

    localparam int NM = DATA_W / ML;
    localparam int PW = 2 * ML;

    logic [NM-1:0][PW-1:0] prod;

    for (genvar k = 0; k < NM; k++) begin : g_prod
        assign prod[k] = PW'($signed(a[k*ML +: ML]) * $signed(b[k*ML +: ML]));
        assign mul_lo[k*ML +: ML] = prod[k][ML-1:0];
    end

    for (genvar j = 0; j < NM / 2; j++) begin : g_pair
        assign madd[j*PW +: PW] = prod[2*j] + prod[2*j+1];
    end

endmodule

// File: rtl/simd_narrow.sv
module simd_narrow #(
    parameter int SW = 16
) (
    input  logic [SW-1:0]   x,
    output logic [SW/2-1:0] y
);

    localparam int DW = SW / 2;

    logic fits_d;

    always_comb begin
        fits_d = (x[SW-1:DW-1] == {(SW-DW+1){1'b0}}) ||
                 (x[SW-1:DW-1] == {(SW-DW+1){1'b1}});
        if (fits_d)       y = x[DW-1:0];
        else if (x[SW-1]) y = {1'b1, {(DW-1){1'b0}}};
        else              y = {1'b0, {(DW-1){1'b1}}};
    end

endmodule

// File: rtl/simd_pack.sv
module simd_pack
    import simd_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              wide,
    output logic [DATA_W-1:0] res
);

    logic [1:0][DATA_W-1:0] res_w;

    for (genvar g = 0; g < 2; g++) begin : g_src
        localparam int SW = 16 << g;
        localparam int DW = SW / 2;
        localparam int NS = DATA_W / SW;

        for (genvar k = 0; k < NS; k++) begin : g_lane
            simd_narrow #(.SW(SW)) u_na (
                .x (a[k*SW +: SW]),
                .y (res_w[g][k*DW +: DW])
            );
            simd_narrow #(.SW(SW)) u_nb (
                .x (b[k*SW +: SW]),
                .y (res_w[g][(NS+k)*DW +: DW])
            );
        end
    end

    assign res = wide ? res_w[1] : res_w[0];

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
    import simd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [WSEL_W-1:0] wsel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);

    simd_op_e   op_e;
    logic       sub_d, sat_s_d, sat_u_d;
    logic [DATA_W-1:0] sum, shl, shr, sra, ceq, cgt, mul_lo, madd, packed_r;
    out_stage_t stage_d, stage_q;

    always_comb begin
        op_e    = simd_op_e'(op);
        sub_d   = (op_e == OP_SUB) || (op_e == OP_SUBS) || (op_e == OP_SUBUS);
        sat_s_d = (op_e == OP_ADDS) || (op_e == OP_SUBS);
        sat_u_d = (op_e == OP_ADDUS) || (op_e == OP_SUBUS);
    end

    simd_lanes u_lanes (
        .a     (a),
        .b     (b),
        .wsel  (wsel),
        .sub   (sub_d),
        .sat_s (sat_s_d),
        .sat_u (sat_u_d),
        .sum   (sum),
        .shl   (shl),
        .shr   (shr),
        .sra   (sra),
        .ceq   (ceq),
        .cgt   (cgt)
    );

    simd_mul #(.ML(16)) u_mul (
        .a      (a),
        .b      (b),
        .mul_lo (mul_lo),
        .madd   (madd)
    );

    simd_pack u_pack (
        .a    (a),
        .b    (b),
        .wide (wsel[1]),
        .res  (packed_r)
    );

    always_comb begin
        stage_d     = stage_q;
        stage_d.vld = in_valid;
        if (in_valid) begin
            case (op_e)
                OP_ADD, OP_ADDS, OP_ADDUS,
                OP_SUB, OP_SUBS, OP_SUBUS: stage_d.res = sum;
                OP_SLL:  stage_d.res = shl;
                OP_SRL:  stage_d.res = shr;
                OP_SRA:  stage_d.res = sra;
                OP_AND:  stage_d.res = a & b;
                OP_ANDN: stage_d.res = ~a & b;
                OP_OR:   stage_d.res = a | b;
                OP_XOR:  stage_d.res = a ^ b;
                OP_CEQ:  stage_d.res = ceq;
                OP_CGT:  stage_d.res = cgt;
                OP_MUL:  stage_d.res = mul_lo;
                OP_MADD: stage_d.res = madd;
                OP_PACK: stage_d.res = packed_r;
                default: stage_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign out_valid = stage_q.vld;
    assign result    = stage_q.res;

endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
    import simd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R8
    cmp_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd13 && a == b) |=> (result == {DATA_W{1'b1}}));

    // R5
    usat_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd2 && a == {DATA_W{1'b1}}) |=> (result == {DATA_W{1'b1}}));

    // R7
    xor_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd12 && a == b) |=> (result == '0));

    // R5
    usub_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 5'd5 && a == '0) |=> (result == '0));

endmodule

bind simd_sat_alu simd_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_simd_sat_alu.sv
module tb_simd_sat_alu;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  op = '0;
    logic [1:0]  wsel = '0;
    logic [63:0] a = '0;
    logic [63:0] b = '0;
    logic        out_valid;
    logic [63:0] result;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t       sbq[$];
    int          n_chk = 0;
    int          n_bad = 0;
    logic [63:0] last_exp = '0;

    simd_sat_alu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .wsel      (wsel),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .result    (result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic longint clamp(input longint v, input longint lo, input longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic logic [63:0] model(input int opc, input int w,
                                          input logic [63:0] x, input logic [63:0] y);
        logic [63:0] r = '0;
        int lw, n;
        longint mask, half, ua, ub, sa, sb, v;
        lw = (w == 0) ? 8 : (w == 1) ? 16 : 32;
        if (opc == 15 || opc == 16) lw = 16;
        if (opc == 17) lw = (w >= 2) ? 32 : 16;
        mask = (longint'(1) << lw) - 1;
        half = longint'(1) << (lw - 1);
        n = 64 / lw;
        case (opc)
            9:  return x & y;
            10: return ~x & y;
            11: return x | y;
            12: return x ^ y;
            16: begin
                for (int j = 0; j < 2; j++) begin
                    v = 0;
                    for (int t = 0; t < 2; t++) begin
                        ua = longint'(x >> ((2*j+t)*16)) & 64'hFFFF;
                        ub = longint'(y >> ((2*j+t)*16)) & 64'hFFFF;
                        sa = (ua >= 32768) ? ua - 65536 : ua;
                        sb = (ub >= 32768) ? ub - 65536 : ub;
                        v += sa * sb;
                    end
                    r |= (64'(v) & 64'hFFFF_FFFF) << (32*j);
                end
                return r;
            end
            17: begin
                int dl;
                longint dmask, dhalf;
                dl = lw / 2;
                dmask = (longint'(1) << dl) - 1;
                dhalf = longint'(1) << (dl - 1);
                for (int i = 0; i < n; i++) begin
                    ua = longint'(x >> (i*lw)) & mask;
                    ub = longint'(y >> (i*lw)) & mask;
                    sa = (ua >= half) ? ua - 2*half : ua;
                    sb = (ub >= half) ? ub - 2*half : ub;
                    r |= (64'(clamp(sa, -dhalf, dhalf-1)) & 64'(dmask)) << (i*dl);
                    r |= (64'(clamp(sb, -dhalf, dhalf-1)) & 64'(dmask)) << ((n+i)*dl);
                end
                return r;
            end
            default: ;
        endcase
        for (int i = 0; i < n; i++) begin
            ua = longint'(x >> (i*lw)) & mask;
            ub = longint'(y >> (i*lw)) & mask;
            sa = (ua >= half) ? ua - 2*half : ua;
            sb = (ub >= half) ? ub - 2*half : ub;
            case (opc)
                0:  v = ua + ub;
                1:  v = clamp(sa + sb, -half, half - 1);
                2:  v = clamp(ua + ub, 0, mask);
                3:  v = ua - ub;
                4:  v = clamp(sa - sb, -half, half - 1);
                5:  v = (ua < ub) ? 0 : ua - ub;
                6:  v = (y >= 64'(lw)) ? 0 : (ua << y[5:0]);
                7:  v = (y >= 64'(lw)) ? 0 : (ua >> y[5:0]);
                8:  v = (y >= 64'(lw)) ? ((sa < 0) ? -1 : 0) : (sa >>> y[5:0]);
                13: v = (ua == ub) ? -1 : 0;
                14: v = (sa > sb) ? -1 : 0;
                15: v = sa * sb;
                default: v = 0;
            endcase
            r |= (64'(v) & 64'(mask)) << (i*lw);
        end
        return r;
    endfunction

    task automatic send(input int opc, input int w, input logic [63:0] x,
                        input logic [63:0] y, input string tag);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        op   = 5'(opc);
        wsel = 2'(w);
        a    = x;
        b    = y;
        it.exp = model(opc, w, x, y);
        it.tag = tag;
        last_exp = it.exp;
        sbq.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        a = 64'hDEAD_BEEF_0BAD_F00D;
    endtask

    // monitor: pops one expected item per valid result
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sbq.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R2 unexpected result actual=%h expected=none", result);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    check(it.tag, result, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        op = 5'd0; a = '1; b = '1;
        repeat (3) @(negedge clk);
        check("R1 reset valid", 64'(out_valid), 64'd0);
        check("R1 reset result", result, 64'd0);
        rst_n = 1'b1;

        // R3 wrap, lanes do not leak carries
        send(0, 0, 64'h00FF_7F80_FF01_FFFF, 64'h0101_0180_0101_0001, "R3 add8");
        send(0, 1, 64'h0000_FFFF_7FFF_1234, 64'h0001_0001_0001_4321, "R3 add16");
        send(3, 2, 64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, "R3 sub32");
        send(0, 3, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, "R3 add w3");
        send(3, 0, 64'h0010_2030_4050_6070, 64'h0111_1111_1111_1171, "R3 sub8");
        // R4 signed saturation, one lane clamps, its neighbour does not
        send(1, 0, 64'h7F80_7F80_0102_7F80, 64'h01FF_8001_0102_0080, "R4 adds8");
        send(4, 1, 64'h8000_7FFF_0005_7FFF, 64'h0001_FFFF_0007_8000, "R4 subs16");
        send(1, 2, 64'h7FFF_FFFF_8000_0000, 64'h0000_0001_FFFF_FFFF, "R4 adds32");
        // R5 unsigned saturation
        send(2, 1, 64'hFFFF_FFF0_0001_8000, 64'h0001_0010_0001_8000, "R5 addus16");
        send(5, 0, 64'h0010_FF00_0102_0304, 64'h0011_0001_0101_0403, "R5 subus8");
        send(2, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, "R5 addus8 top");
        // R6 shifts
        send(6, 0, 64'h8142_2418_FF01_8001, 64'd3, "R6 sll8");
        send(7, 1, 64'h8000_FFFF_1234_0001, 64'd15, "R6 srl16");
        send(8, 1, 64'h8000_7FFF_F234_0001, 64'd16, "R6 sra16 big");
        send(7, 2, 64'hFFFF_FFFF_8000_0000, 64'h1_0000_0001, "R6 srl32 huge");
        send(8, 0, 64'h8070_F00F_8001_7F80, 64'd4, "R6 sra8");
        send(6, 2, 64'h0000_0001_8000_0001, 64'd32, "R6 sll32 big");
        // R7 logic, width ignored
        send(9,  1, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1234_5678, "R7 and");
        send(10, 2, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1234_5678, "R7 andn");
        send(11, 0, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1234_5678, "R7 or");
        send(12, 3, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_1234_5678, "R7 xor");
        // R8 compares
        send(13, 0, 64'h0102_0304_0506_0708, 64'h0102_0300_0506_0008, "R8 eq8");
        send(14, 1, 64'h8000_7FFF_0001_FFFF, 64'h7FFF_8000_0001_FFFE, "R8 gt16");
        send(14, 2, 64'hFFFF_FFFF_0000_0002, 64'h0000_0000_0000_0001, "R8 gt32");
        // R9 / R10 multiply
        send(15, 0, 64'h8000_7FFF_0100_FFFF, 64'h8000_0002_0100_0003, "R9 mul");
        send(16, 0, 64'h8000_8000_0003_FFFE, 64'h8000_8000_0004_0005, "R10 madd");
        send(16, 2, 64'h7FFF_0001_1234_FFFF, 64'h7FFF_FFFF_0010_FFFF, "R10 madd b");
        // R11 pack
        send(17, 1, 64'h0080_FF7F_007F_FF80, 64'h1234_8000_0001_FFFF, "R11 pack16");
        send(17, 2, 64'h0000_8000_FFFF_7FFF, 64'hFFFF_FFFF_0001_0000, "R11 pack32");
        send(20, 0, 64'h1234_5678_9ABC_DEF0, 64'h1, "R11 unused op");
        send(8, 2, 64'h8000_0000_7FFF_FFFF, 64'd31, "R6 sra32");

        idle();
        @(negedge clk);
        check("R2 idle valid", 64'(out_valid), 64'd0);
        check("R2 hold result", result, last_exp);
        repeat (2) @(negedge clk);
        check("R2 hold result late", result, last_exp);
        check("R2 queue drained", 64'(sbq.size()), 64'd0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule